// File: doc/BRIEF.md
# Supervisor Interrupt Filter and Router

This block decides, every cycle, whether an interrupt should be taken, which cause number wins, and whether the trap is handled at supervisor level or at machine level. It combines real pending interrupts with virtual interrupts that machine-level firmware injects for supervisor software.

A virtual interrupt is built from a per-bit virtual-enable vector, a virtual-pending vector and a separate supervisor enable shadow. It is merged into the supervisor candidate set. Such an interrupt reaches supervisor level without any delegation bit and without any hardware source behind it. Machine firmware can use this to stop delegating a source, take that source itself, and re-inject it selectively.

The block is combinational up to one output register stage. It has no storage of its own: the state registers that hold the interrupt vectors live elsewhere. It also produces a wake indication for a hart stalled in wait-for-interrupt.

Top module: `irq_route_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next values of `irq_req`, `irq_cause`, `irq_to_s` and `wfi_wake` are all zero.
- R2: Bit c is a machine candidate when `ip[c]`, `ie[c]` are 1 and `deleg[c]` is 0. Machine candidates are taken when `priv` is not 3 (M), or when `priv` is 3 and `m_gie` is 1.
- R3: Bit c is a real supervisor candidate when `ip[c]`, `ie[c]`, `deleg[c]` are 1 and `h_deleg[c]` is 0. The supervisor set is taken only when `priv` is 0 (U), or when `priv` is 1 (S) and `s_gie` is 1. It is never taken at `priv` 3 or 2.
- R4: The filtered virtual vector is `vpend & ven & ~deleg & s_ie`. It is ORed into the supervisor candidate set.
- R5: Bits 2, 6 and 10 never enter the supervisor candidate set, whether they come from real or virtual sources.
- R6: If any machine candidate is taken, the selection is made among machine candidates only. Supervisor candidates are considered only when no machine candidate is taken.
- R7: Within a set, the priority from highest to lowest is 11, 3, 7, 9, 1, 5. Bits 63 down to 13 follow, with higher numbers winning. Last come the remaining bits 12, 10, 8, 6, 4, 2, 0, with higher numbers winning.
- R8: `irq_to_s` is 1 for a selected cause c exactly when `priv` is not 3 and either `deleg[c]` is 1 or c is injected. Cause c is injected when `vpend[c]` and `ven[c]` are 1 and `ip[c]` is 0.
- R9: `wfi_wake` is 1 when `ip & ie` is non-zero or the filtered virtual vector of R4 is non-zero, whatever the values of `priv`, `m_gie`, `s_gie` and `h_deleg`.
- R10: All outputs are registered and reflect the inputs of the previous clock edge. `irq_req` drops in the cycle after the candidate sets become empty. `irq_cause` and `irq_to_s` read 0 when `irq_req` is 0.
- R11: A virtual interrupt at bits 14 to 63 is delivered to supervisor level with `irq_to_s` set even when `ip` and `deleg` are zero at that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ip | input | 64 | Real pending interrupt bits |
| ie | input | 64 | Machine enable bits |
| s_ie | input | 64 | Supervisor enable shadow, used for virtual bits |
| deleg | input | 64 | Interrupt delegation to supervisor |
| h_deleg | input | 64 | Delegation onward to the guest level (removes bits from the supervisor set) |
| ven | input | 64 | Virtual interrupt enable |
| vpend | input | 64 | Virtual interrupt pending |
| priv | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| irq_req | output | 1 | An interrupt is to be taken |
| irq_cause | output | 6 | Selected cause number |
| irq_to_s | output | 1 | The trap targets supervisor level |
| wfi_wake | output | 1 | Wake from wait-for-interrupt |

## Verification
The assertions assume that `priv` never takes the reserved value 2. The stimulus only draws privilege from {0, 1, 3}, apart from directed cases that check the reserved value never yields a supervisor trap.

The assertions also take the input vectors to be stable between edges, and the bench drives them on the falling edge only. Random vectors are thinned by ANDing several draws together, so that the candidate sets are often empty or hold a single bit, and the drop and priority corners get covered.

// File: rtl/irq_route_pkg.sv
// Shared constants and helpers for the supervisor interrupt router.
// Assumes interrupt vectors of NIRQ bits with the standard cause layout.
package irq_route_pkg;

    localparam int unsigned NIRQ = 64;
    localparam int unsigned CW   = $clog2(NIRQ);
    localparam int unsigned RW   = 8;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    // Priority score of a cause number: larger wins; scores are unique.
    function automatic logic [RW-1:0] irq_rank(input int unsigned n);
        case (n)
            11:      return RW'(127);
            3:       return RW'(126);
            7:       return RW'(125);
            9:       return RW'(124);
            1:       return RW'(123);
            5:       return RW'(122);
            default: return (n >= 13) ? RW'(n + 50) : RW'(n);
        endcase
    endfunction

    // Guest-level bits that never reach the supervisor set.
    function automatic logic [NIRQ-1:0] vs_bits();
        logic [NIRQ-1:0] m;
        m = '0;
        m[2]  = 1'b1;
        m[6]  = 1'b1;
        m[10] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_cand.sv
// Candidate builder: forms the machine and supervisor candidate vectors,
// the filtered virtual vector, the injected vector and the raw wake term.
// Assumes all input vectors are stable for the whole cycle.
module irq_cand
    import irq_route_pkg::*;
#(
    parameter int unsigned N = NIRQ
) (
    input  logic [N-1:0] ip,
    input  logic [N-1:0] ie,
    input  logic [N-1:0] s_ie,
    input  logic [N-1:0] deleg,
    input  logic [N-1:0] h_deleg,
    input  logic [N-1:0] ven,
    input  logic [N-1:0] vpend,
    input  logic [1:0]   priv,
    input  logic         m_gie,
    input  logic         s_gie,
    output logic [N-1:0] m_cand,
    output logic [N-1:0] s_cand,
    output logic [N-1:0] injected,
    output logic         wake_raw
);

    localparam logic [N-1:0] VS_EXCL = N'(vs_bits());

    logic [N-1:0] pend;
    logic [N-1:0] virt_flt;
    logic         m_open;
    logic         s_open;

    // Purpose: global gates for each level from privilege and enables.
    always_comb begin
        m_open = (priv != PRIV_M) || m_gie;
        s_open = (priv == PRIV_U) || ((priv == PRIV_S) && s_gie);
    end

    // Purpose: build the candidate vectors and the wake term.
    always_comb begin
        pend     = ip & ie;
        virt_flt = vpend & ven & ~deleg & s_ie;
        injected = vpend & ven & ~ip;
        m_cand   = m_open ? (pend & ~deleg) : '0;
        s_cand   = s_open ? (((pend & deleg & ~h_deleg) | virt_flt) & ~VS_EXCL) : '0;
        wake_raw = (|pend) || (|virt_flt);
    end

endmodule

// File: rtl/irq_pick.sv
// Fixed-priority picker: returns the highest-ranked set bit of a vector.
// Assumes irq_rank gives unique scores for all N bits.
module irq_pick
    import irq_route_pkg::*;
#(
    parameter int unsigned N = NIRQ,
    localparam int unsigned W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cand,
    output logic         any,
    output logic [W-1:0] cause
);

    logic [RW-1:0] best;

    // Purpose: scan all bits and keep the one with the largest score.
    always_comb begin
        any   = 1'b0;
        cause = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!any || irq_rank(i) > best)) begin
                any   = 1'b1;
                cause = W'(i);
                best  = irq_rank(i);
            end
        end
    end

    // R7: a reported winner is always a member of the candidate set.
    assert_pick_member_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> cand[cause]);

    // R7: a non-empty set always produces a winner.
    assert_pick_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|cand) |-> any);

endmodule

// File: rtl/irq_route_unit.sv
// Supervisor interrupt filter and router (top). Merges real and virtual
// interrupts, selects machine before supervisor candidates, decides the
// target level and registers the result once per cycle.
// Assumes priv never holds the reserved value 2 in normal operation.
module irq_route_unit
    import irq_route_pkg::*;
#(
    parameter int unsigned N = NIRQ,
    localparam int unsigned W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ip,
    input  logic [N-1:0] ie,
    input  logic [N-1:0] s_ie,
    input  logic [N-1:0] deleg,
    input  logic [N-1:0] h_deleg,
    input  logic [N-1:0] ven,
    input  logic [N-1:0] vpend,
    input  logic [1:0]   priv,
    input  logic         m_gie,
    input  logic         s_gie,
    output logic         irq_req,
    output logic [W-1:0] irq_cause,
    output logic         irq_to_s,
    output logic         wfi_wake
);

    logic [N-1:0] lane_cand [2];
    logic         lane_any  [2];
    logic [W-1:0] lane_cause[2];
    logic [N-1:0] injected;
    logic         wake_raw;
    logic         sel_valid;
    logic [W-1:0] sel_cause;
    logic         sel_to_s;

    irq_cand #(.N(N)) u_cand (
        .ip       (ip),
        .ie       (ie),
        .s_ie     (s_ie),
        .deleg    (deleg),
        .h_deleg  (h_deleg),
        .ven      (ven),
        .vpend    (vpend),
        .priv     (priv),
        .m_gie    (m_gie),
        .s_gie    (s_gie),
        .m_cand   (lane_cand[0]),
        .s_cand   (lane_cand[1]),
        .injected (injected),
        .wake_raw (wake_raw)
    );

    // Lane 0 picks among machine candidates, lane 1 among supervisor ones.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        irq_pick #(.N(N)) u_pick (
            .clk   (clk),
            .rst_n (rst_n),
            .cand  (lane_cand[g]),
            .any   (lane_any[g]),
            .cause (lane_cause[g])
        );
    end

    // Purpose: machine lane wins; then decide the target level.
    always_comb begin
        sel_valid = lane_any[0] || lane_any[1];
        sel_cause = lane_any[0] ? lane_cause[0] : (lane_any[1] ? lane_cause[1] : '0);
        sel_to_s  = sel_valid && (priv != PRIV_M) &&
                    (deleg[sel_cause] || injected[sel_cause]);
    end

    // Purpose: register the decision and the wake flag once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req   <= 1'b0;
            irq_cause <= '0;
            irq_to_s  <= 1'b0;
            wfi_wake  <= 1'b0;
        end else begin
            irq_req   <= sel_valid;
            irq_cause <= sel_cause;
            irq_to_s  <= sel_to_s;
            wfi_wake  <= wake_raw;
        end
    end

    // R8: no supervisor-level trap is produced while running in M.
    assert_no_s_from_m_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (priv == PRIV_M) |=> !irq_to_s);

    // R6: a machine winner never targets supervisor level.
    assert_machine_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lane_any[0] |=> (irq_req && !irq_to_s));

    // R9: any request implies the wake flag in the same cycle.
    assert_req_wakes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> wfi_wake);

    // R10: empty candidate sets drop the request one cycle later.
    assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!lane_any[0] && !lane_any[1]) |=> (!irq_req && irq_cause == '0 && !irq_to_s));

    // R5: the supervisor lane never selects a guest-level bit.
    assert_no_vs_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lane_any[1] |-> (lane_cause[1] != W'(2) && lane_cause[1] != W'(6) &&
                         lane_cause[1] != W'(10)));

endmodule

// File: tb/tb_irq_route_unit.sv
// Self-checking bench: directed corners plus seeded random stimulus,
// compared against a model computed from the requirements.
module tb_irq_route_unit;

    localparam int N = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  ip, ie, s_ie, deleg, h_deleg, ven, vpend;
    logic [1:0]    priv;
    logic          m_gie, s_gie;
    logic          irq_req;
    logic [5:0]    irq_cause;
    logic          irq_to_s;
    logic          wfi_wake;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_route_unit dut (
        .clk(clk), .rst_n(rst_n), .ip(ip), .ie(ie), .s_ie(s_ie),
        .deleg(deleg), .h_deleg(h_deleg), .ven(ven), .vpend(vpend),
        .priv(priv), .m_gie(m_gie), .s_gie(s_gie),
        .irq_req(irq_req), .irq_cause(irq_cause), .irq_to_s(irq_to_s),
        .wfi_wake(wfi_wake)
    );

    // Score from R7.
    function automatic int score(input int b);
        int order[6] = '{11, 3, 7, 9, 1, 5};
        for (int k = 0; k < 6; k++) if (order[k] == b) return 1000 - k;
        if (b >= 13) return 100 + b;
        return b;
    endfunction

    function automatic int pick(input logic [N-1:0] v);
        int w = -1;
        for (int b = 0; b < N; b++)
            if (v[b] && (w < 0 || score(b) > score(w))) w = b;
        return w;
    endfunction

    // Expected outputs {req, cause, to_s, wake} from R2..R11.
    function automatic logic [8:0] model();
        logic [N-1:0] pend, vf, mc, sc, inj;
        logic         mo, so, req, tos;
        int           c;
        pend = ip & ie;
        vf   = vpend & ven & ~deleg & s_ie;
        inj  = vpend & ven & ~ip;
        mo   = (priv != 2'd3) || m_gie;
        so   = (priv == 2'd0) || (priv == 2'd1 && s_gie);
        mc   = mo ? (pend & ~deleg) : '0;
        sc   = so ? ((pend & deleg & ~h_deleg) | vf) : '0;
        sc[2] = 1'b0; sc[6] = 1'b0; sc[10] = 1'b0;
        c    = (mc != 0) ? pick(mc) : pick(sc);
        req  = (c >= 0);
        if (!req) c = 0;
        tos  = req && priv != 2'd3 && (deleg[c] || inj[c]);
        return {req, 6'(c), tos, (pend != 0) || (vf != 0)};
    endfunction

    task automatic clear_in();
        ip = '0; ie = '0; s_ie = '0; deleg = '0; h_deleg = '0;
        ven = '0; vpend = '0; priv = 2'd3; m_gie = 1'b0; s_gie = 1'b0;
    endtask

    // Apply current inputs, wait one edge, compare at the falling edge.
    task automatic step(input string req_tag);
        logic [8:0] exp_v, act_v;
        exp_v = model();
        @(negedge clk);
        act_v = {irq_req, irq_cause, irq_to_s, wfi_wake};
        n_chk++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual req=%0b cause=%0d to_s=%0b wake=%0b expected req=%0b cause=%0d to_s=%0b wake=%0b",
                req_tag, act_v[8], act_v[7:2], act_v[1], act_v[0],
                exp_v[8], exp_v[7:2], exp_v[1], exp_v[0]);
        end
    endtask

    function automatic logic [N-1:0] sparse();
        return {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int seed_unused;
        seed_unused = $urandom(32'h5eed_1234);
        clear_in();
        ip = '1; ie = '1;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        n_chk++;
        // R1: reset state
        if ({irq_req, irq_cause, irq_to_s, wfi_wake} !== 9'd0) begin
            n_bad++;
            $display("FAIL R1: actual %b expected 0", {irq_req, irq_cause, irq_to_s, wfi_wake});
        end
        rst_n = 1'b1;

        // R2: machine timer in M with global enable
        clear_in(); ip[7] = 1; ie[7] = 1; m_gie = 1; step("R2");
        // R2: gated in M without global enable; wake still set (R9)
        m_gie = 0; step("R2/R9");
        // R2: taken from S regardless of m_gie
        priv = 2'd1; step("R2");
        // R3: delegated supervisor external from U
        clear_in(); priv = 2'd0; ip[9] = 1; ie[9] = 1; deleg[9] = 1; step("R3");
        // R3: S with s_gie off -> none
        priv = 2'd1; step("R3");
        s_gie = 1; step("R3");
        // R3: never in M, and reserved privilege gives no supervisor trap
        priv = 2'd3; m_gie = 1; step("R3");
        priv = 2'd2; step("R3");
        // R3: h_deleg removes the bit
        priv = 2'd0; h_deleg[9] = 1; step("R3");
        // R4: virtual bit 1 filtered by s_ie
        clear_in(); priv = 2'd0; ven[1] = 1; vpend[1] = 1; step("R4");
        s_ie[1] = 1; step("R4/R8");
        deleg[1] = 1; step("R4");
        // R5: guest bits excluded, real and virtual
        clear_in(); priv = 2'd0; ip[6] = 1; ie[6] = 1; deleg[6] = 1; step("R5");
        ven[10] = 1; vpend[10] = 1; s_ie[10] = 1; step("R5");
        // R6: machine beats higher-ranked supervisor
        clear_in(); priv = 2'd1; s_gie = 1;
        ip[9] = 1; ie[9] = 1; deleg[9] = 1; ip[5] = 1; ie[5] = 1; step("R6");
        // R7: priority among machine bits
        clear_in(); priv = 2'd0; ip = 64'h8000_0000_0000_2888; ie = '1; step("R7");
        ip[11] = 0; step("R7");
        ip = 64'h0000_0000_0001_6000; step("R7");
        ip = 64'h0000_0000_0000_1401; step("R7");
        // R8: injected cause with real source low
        clear_in(); priv = 2'd1; s_gie = 1; ven[13] = 1; vpend[13] = 1; s_ie[13] = 1; step("R8");
        // R11: virtual-only cause 40 and 63
        clear_in(); priv = 2'd0; ven[40] = 1; vpend[40] = 1; s_ie[40] = 1; step("R11");
        ven[63] = 1; vpend[63] = 1; s_ie[63] = 1; step("R11");
        // R10: drop after empty
        clear_in(); step("R10");
        step("R10");

        // Random mix
        for (int it = 0; it < 3000; it++) begin
            ip = sparse(); ie = sparse() | sparse(); s_ie = sparse() | sparse();
            deleg = {$urandom, $urandom}; h_deleg = sparse();
            ven = {$urandom, $urandom}; vpend = sparse();
            case ($urandom_range(2)) 0: priv = 2'd0; 1: priv = 2'd1; default: priv = 2'd3; endcase
            m_gie = 1'($urandom); s_gie = 1'($urandom);
            step("R2/R3/R4/R6/R7/R8/R9");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule